// File: doc/BRIEF.md
# GPIB Interface Interrupt Status and Mask Unit

This block gathers the event pulses produced by the rest of a GPIB talker/listener interface into two 8-bit status registers. The pulses come from the handshake, the command decoder, the remote/local logic and the addressing logic. Each latched bit stays set until the host reads its register. That read returns the value and clears the latched bits in the same access. A pair of mask registers chooses which latched bits drive the single interrupt output. Bits are latched whether or not they are enabled.

The second register mixes two kinds of bit. Four of its bits are latched events: serial poll complete, and three sticky change flags for the lockout, remote and addressed states. The other four are live status levels, which cannot be masked and never interrupt. The second mask register also holds the two DMA request enables.

The host side is a plain register port with a read strobe, a write strobe and a small address. Reads are combinational within the strobe cycle. The clearing takes effect on the clock edge that ends that cycle.

Top module: `gpib_irq_unit`

## Requirements
- R1: After reset, both status registers read 0, both masks are 0, and `irq`, `dmaOutEn` and `dmaInEn` are low.
- R2: A one-cycle pulse on `ev1Pulse[i]` sets bit i of status register 1, read at address 0, even when mask 1 bit i is 0. The bit meanings from 7 down to 0 are: undefined command, secondary address pass, group trigger, end, device clear, error, byte-out, byte-in.
- R3: A read of address 0 returns the latched status 1 and clears it. A second read with no new events returns 0.
- R4: A write to address 0 loads mask 1. `irq` is the OR of the status 1 bits ANDed with mask 1 and the status 2 bits [3:0] ANDed with mask 2 [3:0]. `irq` falls in the cycle after the read that clears the responsible bits.
- R5: An event that arrives in the same cycle as a clearing read is absent from that read's data and present in the next read.
- R6: Status register 2, read at address 1, shows levels in bits 7 to 4: bit 7 is `irq`, bit 6 is serial-poll-active, bit 5 is lockout and bit 4 is remote. These bits are not cleared by a read, have no mask bit and never raise `irq`.
- R7: Status register 2 bits [3:0] are latched events: bit 3 is serial poll complete (`spollDone`), bit 2 is lockout change, bit 1 is remote change and bit 0 is address change. A read clears them, and mask 2 bits [3:0], written at address 1, enable them onto `irq`.
- R8: A change bit is set by any transition of its level. It stays set through several transitions and reads 1 once.
- R9: The address change bit is not set while `talkOnly` or `listenOnly` is high.
- R10: Mask 2 bit 5 drives `dmaOutEn` and bit 4 drives `dmaInEn`. Bits 7 and 6 of a mask 2 write have no effect on any output. The enables change only on a write to address 1.
- R11: Reads at addresses 2 and 3 return 0 and clear nothing. Writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset (power-on clear) |
| rdStb | input | 1 | Register read strobe, one cycle per access |
| wrStb | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the strobe cycle |
| ev1Pulse | input | 8 | Event pulses for status register 1 |
| spollDone | input | 1 | Serial poll complete pulse |
| spollActLvl | input | 1 | Serial poll active level |
| lockoutLvl | input | 1 | Local lockout level |
| remoteLvl | input | 1 | Remote state level |
| addressedLvl | input | 1 | Addressed (talker or listener) level |
| talkOnly | input | 1 | Talk-only mode, suppresses address change |
| listenOnly | input | 1 | Listen-only mode, suppresses address change |
| irq | output | 1 | Combined interrupt output |
| dmaOutEn | output | 1 | DMA output enable from mask 2 |
| dmaInEn | output | 1 | DMA input enable from mask 2 |

## Verification
The bench builds the block with the default `ADDR_W` of 2. At that width the whole address space is reachable, including the two unused addresses that must read 0 and must not clear anything. The bench places a clearing read in the same cycle as an event pulse to cover the read/event overlap. It toggles the addressed level twice between reads to cover the sticky change behaviour, and it repeats that toggle in both the talk-only and the listen-only mode.

// File: rtl/gpib_irq_pkg.sv
`timescale 1ns/1ps
package gpib_irq_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned EV2_W = 4;

  // status register 2 bit positions
  localparam int unsigned S2_ADDR_CHG = 0;
  localparam int unsigned S2_REM_CHG  = 1;
  localparam int unsigned S2_LOCK_CHG = 2;
  localparam int unsigned S2_SPOLL_DN = 3;
  localparam int unsigned S2_REM_LVL  = 4;
  localparam int unsigned S2_LOCK_LVL = 5;
  localparam int unsigned S2_SPA_LVL  = 6;
  localparam int unsigned S2_IRQ_LVL  = 7;

  // mask register 2 DMA enable positions
  localparam int unsigned M2_DMA_IN  = 4;
  localparam int unsigned M2_DMA_OUT = 5;

  typedef struct packed {
    logic rdStat1;
    logic rdStat2;
    logic wrMask1;
    logic wrMask2;
  } regStb_t;
endpackage

// File: rtl/gpib_irq_ctrl.sv
`timescale 1ns/1ps
module gpib_irq_ctrl
  import gpib_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] addr,
  output regStb_t           stb
);
  localparam logic [ADDR_W-1:0] ADR_REG1 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_REG2 = ADDR_W'(1);

  logic hitReg1;
  logic hitReg2;
  logic wrOnly;

  assign hitReg1 = (addr == ADR_REG1);
  assign hitReg2 = (addr == ADR_REG2);
  // a read takes precedence over a write in the same cycle
  assign wrOnly  = wrStb & ~rdStb;

  always_comb begin
    stb         = '0;
    stb.rdStat1 = rdStb  & hitReg1;
    stb.rdStat2 = rdStb  & hitReg2;
    stb.wrMask1 = wrOnly & hitReg1;
    stb.wrMask2 = wrOnly & hitReg2;
  end
endmodule

// File: rtl/gpib_irq_chg.sv
`timescale 1ns/1ps
module gpib_irq_chg (
  input  logic clk,
  input  logic rstN,
  input  logic lvl,
  input  logic suppress,
  output logic chgPulse
);
  logic prevQ;
  logic primedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ   <= 1'b0;
      primedQ <= 1'b0;
    end else begin
      prevQ   <= lvl;
      primedQ <= 1'b1;
    end
  end

  // the first cycle after reset only samples, so no edge is reported for it
  assign chgPulse = primedQ & (lvl ^ prevQ) & ~suppress;
endmodule

// File: rtl/gpib_irq_dpath.sv
`timescale 1ns/1ps
module gpib_irq_dpath
  import gpib_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStb_t          stb,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] ev1Pulse,
  input  logic             spollDone,
  input  logic             spollActLvl,
  input  logic             lockoutLvl,
  input  logic             remoteLvl,
  input  logic             addressedLvl,
  input  logic             noAddrEvt,
  output logic [REG_W-1:0] rdData,
  output logic             irq,
  output logic             dmaOutEn,
  output logic             dmaInEn,
  output logic [REG_W-1:0] mask1Vis,
  output logic [EV2_W-1:0] mask2Vis,
  output logic [EV2_W-1:0] stat2Vis
);
  localparam int unsigned N_CHG = 3;

  logic [REG_W-1:0] stat1Q;
  logic [REG_W-1:0] mask1Q;
  logic [EV2_W-1:0] stat2Q;
  logic [EV2_W-1:0] mask2Q;
  logic             dmaOutQ;
  logic             dmaInQ;
  logic [EV2_W-1:0] ev2;
  logic [N_CHG-1:0] chgLvl;
  logic [N_CHG-1:0] chgSup;
  logic [N_CHG-1:0] chgEv;
  logic [REG_W-1:0] stat2Full;

  // change detectors: index 0 addressed, 1 remote, 2 lockout
  assign chgLvl = {lockoutLvl, remoteLvl, addressedLvl};
  assign chgSup = {1'b0, 1'b0, noAddrEvt};

  for (genvar c = 0; c < N_CHG; c++) begin : g_chg
    gpib_irq_chg u_chg (
      .clk      (clk),
      .rstN     (rstN),
      .lvl      (chgLvl[c]),
      .suppress (chgSup[c]),
      .chgPulse (chgEv[c])
    );
  end

  always_comb begin
    ev2              = '0;
    ev2[S2_ADDR_CHG] = chgEv[0];
    ev2[S2_REM_CHG]  = chgEv[1];
    ev2[S2_LOCK_CHG] = chgEv[2];
    ev2[S2_SPOLL_DN] = spollDone;
  end

  // status register 1: set by event, cleared by read, event wins
  for (genvar i = 0; i < REG_W; i++) begin : g_st1
    always_ff @(posedge clk) begin
      if (!rstN) stat1Q[i] <= 1'b0;
      else       stat1Q[i] <= (stat1Q[i] & ~stb.rdStat1) | ev1Pulse[i];
    end
  end

  for (genvar j = 0; j < EV2_W; j++) begin : g_st2
    always_ff @(posedge clk) begin
      if (!rstN) stat2Q[j] <= 1'b0;
      else       stat2Q[j] <= (stat2Q[j] & ~stb.rdStat2) | ev2[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask1Q  <= '0;
      mask2Q  <= '0;
      dmaOutQ <= 1'b0;
      dmaInQ  <= 1'b0;
    end else begin
      if (stb.wrMask1) mask1Q <= wrData;
      if (stb.wrMask2) begin
        mask2Q  <= wrData[EV2_W-1:0];
        dmaOutQ <= wrData[M2_DMA_OUT];
        dmaInQ  <= wrData[M2_DMA_IN];
      end
    end
  end

  assign irq = (|(stat1Q & mask1Q)) | (|(stat2Q & mask2Q));

  always_comb begin
    stat2Full              = '0;
    stat2Full[EV2_W-1:0]   = stat2Q;
    stat2Full[S2_REM_LVL]  = remoteLvl;
    stat2Full[S2_LOCK_LVL] = lockoutLvl;
    stat2Full[S2_SPA_LVL]  = spollActLvl;
    stat2Full[S2_IRQ_LVL]  = irq;
  end

  always_comb begin
    if (stb.rdStat1)      rdData = stat1Q;
    else if (stb.rdStat2) rdData = stat2Full;
    else                  rdData = '0;
  end

  assign dmaOutEn = dmaOutQ;
  assign dmaInEn  = dmaInQ;
  assign mask1Vis = mask1Q;
  assign mask2Vis = mask2Q;
  assign stat2Vis = stat2Q;
endmodule

// File: rtl/gpib_irq_unit.sv
`timescale 1ns/1ps
module gpib_irq_unit
  import gpib_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [7:0]        ev1Pulse,
  input  logic              spollDone,
  input  logic              spollActLvl,
  input  logic              lockoutLvl,
  input  logic              remoteLvl,
  input  logic              addressedLvl,
  input  logic              talkOnly,
  input  logic              listenOnly,
  output logic              irq,
  output logic              dmaOutEn,
  output logic              dmaInEn
);
  regStb_t          stbW;
  logic [REG_W-1:0] mask1W;
  logic [EV2_W-1:0] mask2W;
  logic [EV2_W-1:0] stat2W;

  gpib_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .rdStb (rdStb),
    .wrStb (wrStb),
    .addr  (addr),
    .stb   (stbW)
  );

  gpib_irq_dpath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stbW),
    .wrData       (wrData),
    .ev1Pulse     (ev1Pulse),
    .spollDone    (spollDone),
    .spollActLvl  (spollActLvl),
    .lockoutLvl   (lockoutLvl),
    .remoteLvl    (remoteLvl),
    .addressedLvl (addressedLvl),
    .noAddrEvt    (talkOnly | listenOnly),
    .rdData       (rdData),
    .irq          (irq),
    .dmaOutEn     (dmaOutEn),
    .dmaInEn      (dmaInEn),
    .mask1Vis     (mask1W),
    .mask2Vis     (mask2W),
    .stat2Vis     (stat2W)
  );
endmodule

// File: rtl/gpib_irq_chk.sv
`timescale 1ns/1ps
module gpib_irq_chk
  import gpib_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdStb,
  input logic              wrStb,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdData,
  input logic [7:0]        ev1Pulse,
  input logic              talkOnly,
  input logic              listenOnly,
  input logic              irq,
  input logic              dmaOutEn,
  input logic              dmaInEn,
  input regStb_t           stb,
  input logic [REG_W-1:0]  mask1W,
  input logic [EV2_W-1:0]  mask2W,
  input logic [EV2_W-1:0]  stat2W
);
  localparam logic [ADDR_W-1:0] A0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(1);

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && addr == A0 && ev1Pulse == '0) |=> (!(rdStb && addr == A0) || rdData == '0)); // R3

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (mask1W == '0 && mask2W == '0) |-> !irq); // R4

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && addr == A0 && ev1Pulse == '0 && mask2W == '0) |=> !irq); // R4

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R11

  AST_ADDR_SUPPRESS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat2W[S2_ADDR_CHG]) |-> !$past(talkOnly || listenOnly)); // R9

  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStb && addr == A1) |=> $stable({dmaOutEn, dmaInEn})); // R10
endmodule

bind gpib_irq_unit gpib_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdStb      (rdStb),
  .wrStb      (wrStb),
  .addr       (addr),
  .rdData     (rdData),
  .ev1Pulse   (ev1Pulse),
  .talkOnly   (talkOnly),
  .listenOnly (listenOnly),
  .irq        (irq),
  .dmaOutEn   (dmaOutEn),
  .dmaInEn    (dmaInEn),
  .stb        (stbW),
  .mask1W     (mask1W),
  .mask2W     (mask2W),
  .stat2W     (stat2W)
);

// File: tb/sim_gpib_irq_unit.sv
`timescale 1ns/1ps
module sim_gpib_irq_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdStb = 1'b0;
  logic       wrStb = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] ev1Pulse = '0;
  logic       spollDone = 1'b0;
  logic       spollActLvl = 1'b0;
  logic       lockoutLvl = 1'b0;
  logic       remoteLvl = 1'b0;
  logic       addressedLvl = 1'b0;
  logic       talkOnly = 1'b0;
  logic       listenOnly = 1'b0;
  logic       irq;
  logic       dmaOutEn;
  logic       dmaInEn;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  gpib_irq_unit #(.ADDR_W(2)) u0 (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .wrStb(wrStb), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ev1Pulse(ev1Pulse),
    .spollDone(spollDone), .spollActLvl(spollActLvl), .lockoutLvl(lockoutLvl),
    .remoteLvl(remoteLvl), .addressedLvl(addressedLvl), .talkOnly(talkOnly),
    .listenOnly(listenOnly), .irq(irq), .dmaOutEn(dmaOutEn), .dmaInEn(dmaInEn)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rdStb = 1'b1; addr = a;
    #1 v = rdData;
    @(negedge clk);
    rdStb = 1'b0;
    #1;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrStb = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrStb = 1'b0;
    #1;
  endtask

  task automatic pulse1(input logic [7:0] b);
    @(negedge clk);
    ev1Pulse = b;
    @(negedge clk);
    ev1Pulse = '0;
    #1;
  endtask

  task automatic tReset();
    logic [7:0] v;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 dma", {6'd0, dmaOutEn, dmaInEn}, 8'h00);
    rdReg(2'd0, v); chk("R1 status1", v, 8'h00);
    rdReg(2'd1, v); chk("R1 status2", v, 8'h00);
  endtask

  task automatic tStatus1Order();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      pulse1(8'(1 << i));
      chk("R2 unmasked irq", {7'd0, irq}, 8'h00);
      rdReg(2'd0, v);
      chk("R2 bit position", v, 8'(1 << i));
    end
  endtask

  task automatic tClearOnRead();
    logic [7:0] v;
    pulse1(8'hA5);
    rdReg(2'd0, v); chk("R3 first read", v, 8'hA5);
    rdReg(2'd0, v); chk("R3 second read", v, 8'h00);
  endtask

  task automatic tMask1();
    logic [7:0] v;
    wrReg(2'd0, 8'h10);
    pulse1(8'h01);
    chk("R4 masked-off irq", {7'd0, irq}, 8'h00);
    pulse1(8'h10);
    chk("R4 enabled irq", {7'd0, irq}, 8'h01);
    rdReg(2'd0, v);
    chk("R4 read value", v, 8'h11);
    chk("R4 irq after read", {7'd0, irq}, 8'h00);
    wrReg(2'd0, 8'h00);
  endtask

  task automatic tSameCycle();
    logic [7:0] v;
    pulse1(8'h01);
    @(negedge clk);
    rdStb = 1'b1; addr = 2'd0; ev1Pulse = 8'h04;
    #1 v = rdData;
    @(negedge clk);
    rdStb = 1'b0; ev1Pulse = '0;
    chk("R5 overlapped read", v, 8'h01);
    rdReg(2'd0, v); chk("R5 following read", v, 8'h04);
  endtask

  task automatic tStatus2Levels();
    logic [7:0] v;
    @(negedge clk);
    remoteLvl = 1'b1; lockoutLvl = 1'b1; spollActLvl = 1'b1;
    @(negedge clk);
    rdReg(2'd1, v); chk("R6 levels plus changes", v, 8'h76);
    rdReg(2'd1, v); chk("R6 levels survive read", v, 8'h70);
    wrReg(2'd1, 8'h0F);
    chk("R6 levels raise no irq", {7'd0, irq}, 8'h00);
    wrReg(2'd0, 8'h01);
    pulse1(8'h01);
    rdReg(2'd1, v); chk("R6 irq level bit", v, 8'hF0);
    rdReg(2'd0, v); chk("R6 status1 side", v, 8'h01);
    wrReg(2'd0, 8'h00);
    wrReg(2'd1, 8'h00);
    @(negedge clk);
    remoteLvl = 1'b0; lockoutLvl = 1'b0; spollActLvl = 1'b0;
    @(negedge clk);
    rdReg(2'd1, v); chk("R6 falling changes", v, 8'h06);
  endtask

  task automatic tStatus2Events();
    logic [7:0] v;
    wrReg(2'd1, 8'h0F);
    @(negedge clk); spollDone = 1'b1;
    @(negedge clk); spollDone = 1'b0;
    #1 chk("R7 spoll done irq", {7'd0, irq}, 8'h01);
    rdReg(2'd1, v); chk("R7 spoll done bit", v, 8'h88);
    chk("R7 irq cleared", {7'd0, irq}, 8'h00);
    @(negedge clk); lockoutLvl = 1'b1;
    @(negedge clk);
    rdReg(2'd1, v); chk("R7 lockout change", v, 8'hA4);
    @(negedge clk); remoteLvl = 1'b1;
    @(negedge clk);
    rdReg(2'd1, v); chk("R7 remote change", v, 8'hB2);
    @(negedge clk); lockoutLvl = 1'b0; remoteLvl = 1'b0;
    @(negedge clk);
    rdReg(2'd1, v); chk("R7 both fall", v, 8'h86);
    wrReg(2'd1, 8'h00);
  endtask

  task automatic tSticky();
    logic [7:0] v;
    @(negedge clk); addressedLvl = 1'b1;
    @(negedge clk); addressedLvl = 1'b0;
    @(negedge clk);
    rdReg(2'd1, v); chk("R8 sticky after two moves", v, 8'h01);
    rdReg(2'd1, v); chk("R8 reads once", v, 8'h00);
  endtask

  task automatic tSuppress();
    logic [7:0] v;
    @(negedge clk); talkOnly = 1'b1;
    @(negedge clk); addressedLvl = 1'b1;
    @(negedge clk); addressedLvl = 1'b0;
    @(negedge clk);
    rdReg(2'd1, v); chk("R9 talk-only suppress", v, 8'h00);
    @(negedge clk); talkOnly = 1'b0; listenOnly = 1'b1;
    @(negedge clk); addressedLvl = 1'b1;
    @(negedge clk);
    rdReg(2'd1, v); chk("R9 listen-only suppress", v, 8'h00);
    @(negedge clk); addressedLvl = 1'b0;
    @(negedge clk); listenOnly = 1'b0;
    @(negedge clk);
    rdReg(2'd1, v); chk("R9 nothing after mode off", v, 8'h00);
  endtask

  task automatic tDma();
    wrReg(2'd1, 8'hF0);
    chk("R10 both enables", {6'd0, dmaOutEn, dmaInEn}, 8'h03);
    chk("R10 upper bits no irq", {7'd0, irq}, 8'h00);
    wrReg(2'd1, 8'hE0);
    chk("R10 out only", {6'd0, dmaOutEn, dmaInEn}, 8'h02);
    wrReg(2'd0, 8'hFF);
    chk("R10 mask1 write keeps dma", {6'd0, dmaOutEn, dmaInEn}, 8'h02);
    wrReg(2'd0, 8'h00);
    wrReg(2'd1, 8'h10);
    chk("R10 in only", {6'd0, dmaOutEn, dmaInEn}, 8'h01);
    wrReg(2'd1, 8'h00);
  endtask

  task automatic tUnusedAddr();
    logic [7:0] v;
    pulse1(8'h02);
    rdReg(2'd2, v); chk("R11 addr2 read", v, 8'h00);
    rdReg(2'd3, v); chk("R11 addr3 read", v, 8'h00);
    wrReg(2'd2, 8'hFF);
    wrReg(2'd3, 8'hFF);
    chk("R11 writes leave masks", {7'd0, irq}, 8'h00);
    chk("R11 writes leave dma", {6'd0, dmaOutEn, dmaInEn}, 8'h00);
    rdReg(2'd0, v); chk("R11 status kept", v, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    tReset();
    tStatus1Order();
    tClearOnRead();
    tMask1();
    tSameCycle();
    tStatus2Levels();
    tStatus2Events();
    tSticky();
    tSuppress();
    tDma();
    tUnusedAddr();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule